// File: doc/BRIEF.md
# Addressed Three-Wire Serial Command Receiver

This block receives control frames from a slow host on a three-wire bus: an enable line, a bus clock and a data line. With the enable line low, the host clocks in an 8-bit device address, least significant bit first. When the enable line rises, the block compares the last eight address bits it received with its own device address. With the enable line high, the host clocks in the data word, first bit first. When the enable line falls, the block delivers the word, but only if the address matched and at least a full word of data bits arrived.

All three bus lines are asynchronous to the system clock. Each passes through a multi-flop synchronizer, and the block finds enable and bus-clock edges in the system clock domain. A host that sends data in whole bytes may pad the front of the data with don't-care bits. The block keeps only the most recent `DATA_W` bits, so a padded frame gives the same word as an unpadded one.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `cmd_word_o` is all zeros and both `cmd_valid_o` and `addr_hit_o` are 0.
- R2: Address bits are taken on rising bus-clock edges while `bus_en_i` is low. The first bit sent is address bit 0. Only the last 8 bits before `bus_en_i` rises are compared with `DEV_ADDR` (default 8'h81, so the bit pattern sent is 1,0,0,0,0,0,0,1). `addr_hit_o` takes the result within 4 system clocks of that rise and holds it until the next rise of `bus_en_i`.
- R3: Data bits are taken on rising bus-clock edges while `bus_en_i` is high. In a frame of exactly 44 data bits, the first bit sent lands in `cmd_word_o[0]` and the last bit sent lands in `cmd_word_o[43]`.
- R4: In a frame with more than 44 data bits, only the last 44 bits sent are kept. The earliest of those becomes `cmd_word_o[0]`.
- R5: When `bus_en_i` falls after a matching address and at least 44 data bits, `cmd_valid_o` pulses within 4 system clocks. `cmd_word_o` takes the new word in the same cycle as the pulse.
- R6: A frame whose address does not match produces no `cmd_valid_o` pulse, and `cmd_word_o` keeps its previous value.
- R7: A frame with fewer than 44 data bits produces no `cmd_valid_o` pulse, and `cmd_word_o` keeps its previous value.
- R8: `cmd_valid_o` is high for exactly one system clock for each accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en_i | input | 1 | Bus enable line: low selects the address phase, high selects the data phase |
| bus_clk_i | input | 1 | Bus clock; bits are taken on its rising edge |
| bus_dat_i | input | 1 | Bus serial data |
| cmd_word_o | output | 44 | Last accepted command word |
| cmd_valid_o | output | 1 | One-cycle strobe when a word is accepted |
| addr_hit_o | output | 1 | Address comparison result from the most recent rise of the enable line |

## Verification
The bench builds the block with its default parameters: a 44-bit word, an 8-bit address equal to 8'h81 and two synchronizer stages. It drives a bus half-period of six system clocks, so many whole frames fit in a short run while every bus edge still passes through the full synchronizer delay. These values cover exact-length and byte-padded frames, address phases longer than eight bits, one-bit-short frames, and mismatches in both the low and the high address bit. Each of these cases gives a precise, hand-computable bit mapping that can be checked against `cmd_word_o`.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_ADDR_W   = 8;
  localparam int unsigned SCR_DATA_W   = 44;
  localparam logic [SCR_ADDR_W-1:0] SCR_DEV_ADDR = 8'h81;
  localparam int unsigned SCR_SYNC_STG = 2;

  // bus line positions inside the synchronized vector
  typedef enum int unsigned {
    LINE_EN  = 0,
    LINE_CLK = 1,
    LINE_DAT = 2
  } scr_line_e;
  localparam int unsigned SCR_LINES = 3;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= '0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/scr_addr_chk.sv
module scr_addr_chk #(
  parameter int unsigned             ADDR_W = 8,
  parameter logic [ADDR_W-1:0]       MATCH  = 8'h81
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en_i,
  input  logic bit_i,
  input  logic check_en_i,
  output logic hit_o
);
  logic [ADDR_W-1:0] sr_q, sr_d;
  logic              hit_q, hit_d;

  always_comb begin
    sr_d  = sr_q;
    hit_d = hit_q;
    if (shift_en_i) sr_d  = {bit_i, sr_q[ADDR_W-1:1]};
    if (check_en_i) hit_d = (sr_q == MATCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R2: the match flag only moves on an enable rise
  p_hit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !check_en_i |=> $stable(hit_o));
  // R2: the bus clock is low whenever the enable line toggles
  p_no_shift_on_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
    check_en_i |-> !shift_en_i);
endmodule

// File: rtl/scr_data_shift.sv
module scr_data_shift #(
  parameter int unsigned DATA_W = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (shift_en_i) begin
      sr_d = {bit_i, sr_q[DATA_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_MAX);

  // R4: the bit counter saturates and never passes the word width
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R7: a clear always empties the frame
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !full_o);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int unsigned              ADDR_W    = SCR_ADDR_W,
  parameter int unsigned              DATA_W    = SCR_DATA_W,
  parameter logic [ADDR_W-1:0]        DEV_ADDR  = SCR_DEV_ADDR,
  parameter int unsigned              SYNC_STG  = SCR_SYNC_STG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en_i,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic [DATA_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  output logic              addr_hit_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [SCR_LINES-1:0] lines_async, lines_s;
  assign lines_async[LINE_EN]  = bus_en_i;
  assign lines_async[LINE_CLK] = bus_clk_i;
  assign lines_async[LINE_DAT] = bus_dat_i;

  scr_sync #(.W(SCR_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (lines_async),
    .level_o (lines_s)
  );

  logic en_s, sclk_s, dat_s;
  assign en_s   = lines_s[LINE_EN];
  assign sclk_s = lines_s[LINE_CLK];
  assign dat_s  = lines_s[LINE_DAT];

  // edge detection in the system domain
  logic en_prev_q, sclk_prev_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_prev_q   <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      en_prev_q   <= en_s;
      sclk_prev_q <= sclk_s;
    end
  end

  logic en_rise, en_fall, sclk_rise;
  assign en_rise   =  en_s & ~en_prev_q;
  assign en_fall   = ~en_s &  en_prev_q;
  assign sclk_rise =  sclk_s & ~sclk_prev_q;

  logic hit;
  scr_addr_chk #(.ADDR_W(ADDR_W), .MATCH(DEV_ADDR)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .shift_en_i (sclk_rise & ~en_s),
    .bit_i      (dat_s),
    .check_en_i (en_rise),
    .hit_o      (hit)
  );

  logic [DATA_W-1:0] shift_word;
  logic              shift_full;
  scr_data_shift #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear_i    (en_rise),
    .shift_en_i (sclk_rise & en_s),
    .bit_i      (dat_s),
    .word_o     (shift_word),
    .full_o     (shift_full)
  );

  // commit on the enable fall
  logic [DATA_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              accept;

  assign accept = en_fall & hit & shift_full;

  always_comb begin
    word_d = word_q;
    vld_d  = accept;
    if (accept) word_d = shift_word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign cmd_word_o  = word_q;
  assign cmd_valid_o = vld_q;
  assign addr_hit_o  = hit;

  // R8: the strobe lasts one cycle
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R6: no strobe without a matched address
  p_strobe_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid_o |-> addr_hit_o);
  // R7: the word only changes together with the strobe
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_valid_o |-> $stable(cmd_word_o));
  // R5: a strobe follows a fall of the synchronized enable
  p_strobe_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid_o |-> !en_prev_q);
endmodule

// File: tb/serial_cmd_rx_tb.sv
module serial_cmd_rx_tb;
  localparam int unsigned DW   = 44;
  localparam int unsigned HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
  logic [DW-1:0] word;
  logic vld, hit;

  always #4 clk = ~clk;

  serial_cmd_rx u_dut (
    .clk (clk), .rst_n (rst_n),
    .bus_en_i (bus_en), .bus_clk_i (bus_clk), .bus_dat_i (bus_dat),
    .cmd_word_o (word), .cmd_valid_o (vld), .addr_hit_o (hit)
  );

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  always @(negedge clk) if (vld) n_strobe++;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(logic b);
    bus_dat = b;
    wait_n(HALF);
    bus_clk = 1'b1;
    wait_n(HALF);
    bus_clk = 1'b0;
  endtask

  // bit i of each vector is the i-th bit sent
  task automatic send_frame(logic [15:0] ab, int an, logic [47:0] db, int dn);
    for (int i = 0; i < an; i++) bus_bit(ab[i]);
    wait_n(HALF);
    bus_en = 1'b1;
    wait_n(HALF);
    for (int i = 0; i < dn; i++) bus_bit(db[i]);
    wait_n(HALF);
    bus_en = 1'b0;
    wait_n(10);
  endtask

  typedef struct packed {
    logic [15:0] ab;
    logic [4:0]  an;
    logic [47:0] db;
    logic [5:0]  dn;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0081, 5'd8,  48'h0CAFE1234567, 6'd44},
    '{16'h0081, 5'd8,  48'hDEADBEEF0123, 6'd48},
    '{16'h0080, 5'd8,  48'h0FF00FF00FF0, 6'd44},
    '{16'h0081, 5'd8,  48'h0555555AAAAA, 6'd43},
    '{16'h0205, 5'd10, 48'h0FFFFFFFFFFF, 6'd44},
    '{16'h0103, 5'd9,  48'h000000000000, 6'd44},
    '{16'h0181, 5'd9,  48'h0A0A0A0A0A0A, 6'd48},
    '{16'h0001, 5'd8,  48'h012345678ABC, 6'd44},
    '{16'h0081, 5'd8,  48'h123456789ABC, 6'd47}
  };

  initial begin
    logic [DW-1:0] model_word;
    model_word = '0;
    wait_n(3);
    // R1: reset state
    check("R1 word", 64'(word), 64'h0);
    check("R1 valid", 64'(vld), 64'h0);
    check("R1 hit", 64'(hit), 64'h0);
    rst_n = 1'b1;
    wait_n(5);

    for (int v = 0; v < NV; v++) begin
      int s0;
      logic [7:0] last_addr;
      logic exp_hit, exp_vld;
      last_addr = VECS[v].ab[int'(VECS[v].an) - 8 +: 8];
      exp_hit = (last_addr == 8'h81);
      exp_vld = exp_hit && (VECS[v].dn >= 6'd44);
      if (exp_vld) model_word = VECS[v].db[int'(VECS[v].dn) - 44 +: 44];
      s0 = n_strobe;
      send_frame(VECS[v].ab, int'(VECS[v].an), VECS[v].db, int'(VECS[v].dn));
      // R2: match decided from the last eight address bits
      check($sformatf("R2 hit vec%0d", v), 64'(hit), 64'(exp_hit));
      // R5 R6 R7 R8: exactly one strobe per accepted frame, none otherwise
      check($sformatf("R8 strobes vec%0d", v), 64'(n_strobe - s0), 64'(exp_vld));
      // R3 R4 (mapping), R6 R7 (held word)
      check($sformatf("R3 R4 word vec%0d", v), 64'(word), 64'(model_word));
    end

    // R6: mismatch in only the high address bit keeps the previous word
    begin
      int s0;
      s0 = n_strobe;
      send_frame(16'h0001, 8, 48'h0FFFFFFFFFFF, 44);
      check("R6 no strobe on high-bit mismatch", 64'(n_strobe - s0), 64'h0);
      check("R6 word held", 64'(word), 64'(model_word));
    end
    // R5: timing of the strobe after the enable fall
    begin
      int lat;
      for (int i = 0; i < 8; i++) bus_bit(((8'h81 >> i) & 1) != 0);
      wait_n(HALF); bus_en = 1'b1; wait_n(HALF);
      for (int i = 0; i < 44; i++) bus_bit(i[0]);
      wait_n(HALF);
      bus_en = 1'b0;
      lat = 0;
      while (!vld && lat < 20) begin wait_n(1); lat++; end
      check("R5 strobe within 4 clocks", 64'(lat <= 4), 64'h1);
      check("R5 word with strobe", 64'(word), {20'h0, {22{2'b10}}});
      wait_n(1);
      check("R8 strobe drops after one cycle", 64'(vld), 64'h0);
      wait_n(10);
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule